// File: doc/BRIEF.md
# Card Host Controller Register and Interrupt Front End

This block is the software-visible register bank of a memory-card host controller, attached to a simple 32-bit bus with one-cycle write and read strobes and a 12-bit byte address. It stores the configuration values the command and data engines consume: power, card clock, command argument, command word, data timer, transfer length and data control. It also holds the response captured from the command engine and exposes the data engine's remaining byte count. The engines themselves sit outside this block. They are started by single-cycle strobes and they report events back as set pulses.

Event pulses from the engines set sticky status bits, which software removes through a write-one-to-clear register. Eleven live FIFO flags are passed straight through into the upper status bits. Two mask registers each select a subset of status bits, and each drives its own registered interrupt line. A window of sixteen word addresses forwards reads and writes to an external data FIFO. A read-only area at the top of the 4 KB space returns eight identification bytes.

Top module: `card_host_regs`

## Requirements
- R1: After reset, every stored register, the sticky status bits, both masks, both interrupt lines and the read data are zero.
- R2: Power (0x00), clock (0x04) and data control (0x2C) keep bits 7:0 of a write, data length (0x28) keeps bits 15:0, and argument (0x08) and data timer (0x24) keep all 32 bits. The discarded bits read back as zero.
- R3: A write to the command register (0x0C) stores bits 10:0. When bit 10 (enable) is 1, `cmd_start` pulses for exactly one cycle, one cycle after the write. The stored bit 10 always reads back as 0.
- R4: A write to data control with bit 0 set pulses `data_start` for one cycle, one cycle after the write. No pulse occurs when bit 0 is clear.
- R5: Status at 0x34 reads as follows: bits 10:0 are sticky event bits, set by pulses on `evt_set`; bits 21:11 are the live `live_flags` input; bits 31:22 are zero.
- R6: Writing to 0x38 clears each sticky bit whose written value is 1, for bits 10:0 only. Live flags are unaffected. A set pulse in the same cycle as a clear wins.
- R7: `irq0` and `irq1` are the registered OR of status ANDed with mask0 (0x3C) or mask1 (0x40) respectively. They follow a status or mask change after one cycle.
- R8: Reading 0x48 returns (byte count + 3) >> 2. Reading 0x30 returns the byte count.
- R9: A read at any word in 0x80 to 0xBC returns `fifo_rdata` and pulses `fifo_pop` in the read cycle. When `fifo_empty` is 1, the read returns 0 and no pop occurs.
- R10: A write in the FIFO window pulses `fifo_push` with the written word one cycle later, but only if the byte count is non-zero. Otherwise the write is ignored.
- R11: Words 0xFE0 to 0xFFC read as 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in that order.
- R12: Reads of unmapped offsets, or of addresses whose bits 1:0 are not zero, return 0. Writes to them change nothing.
- R13: A `rsp_valid` pulse captures `rsp_index` into 0x10 and `rsp_words` into 0x14 (bits 31:0) through 0x20 (bits 127:96).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pwr_ctrl | output | 8 | Power setting |
| clk_ctrl | output | 8 | Card clock setting |
| cmd_arg | output | 32 | Command argument |
| cmd_ctrl | output | 11 | Stored command word |
| cmd_start | output | 1 | Command engine start pulse |
| data_timer | output | 32 | Data timeout value |
| data_len | output | 16 | Transfer length in bytes |
| data_ctrl | output | 8 | Data control setting |
| data_start | output | 1 | Data engine start pulse |
| rsp_valid | input | 1 | Response capture strobe |
| rsp_index | input | 6 | Responding command index |
| rsp_words | input | 128 | Response words, word 0 in bits 31:0 |
| byte_count | input | 16 | Remaining bytes from the data engine |
| evt_set | input | 11 | Sticky status set pulses |
| live_flags | input | 11 | Live FIFO flags for status bits 21:11 |
| fifo_rdata | input | 32 | Head word of the data FIFO |
| fifo_empty | input | 1 | Data FIFO empty |
| fifo_pop | output | 1 | Pop strobe, same cycle as the read |
| fifo_push | output | 1 | Push strobe |
| fifo_wdata | output | 32 | Word to push |
| irq0 | output | 1 | Interrupt line from mask0 |
| irq1 | output | 1 | Interrupt line from mask1 |

## Verification
Results appear at three different times. Read data appears the cycle after the read strobe. The start strobes and the FIFO push appear one cycle after the write. The interrupt lines come one cycle after the sticky bit or mask changes, which makes them two cycles after an event pulse. Only `fifo_pop` is combinational and is due in the read cycle itself. The bench drives every input on the falling edge. Its scoreboard pops an expected read word at the falling edge after each read. The strobe and interrupt checks are sampled at the falling edge that lies one, or for interrupts two, rising edges past the stimulus. The interrupt lines are also confirmed low one edge earlier, so the latency is checked exactly.

// File: rtl/card_host_pkg.sv
// Shared constants for the card host register front end: word offsets,
// field widths and the identification byte function.
package card_host_pkg;
    localparam int unsigned DW       = 32;
    localparam int unsigned AW       = 12;
    localparam int unsigned WIDX_W   = AW - 2;
    localparam int unsigned CFG8_W   = 8;
    localparam int unsigned LEN_W    = 16;
    localparam int unsigned CMD_W    = 11;
    localparam int unsigned IDX_W    = 6;
    localparam int unsigned EVT_W    = 11;
    localparam int unsigned LIVE_W   = 11;
    localparam int unsigned N_IRQ    = 2;
    localparam int unsigned RSP_N    = 4;
    localparam int unsigned CMD_EN_BIT = 10;

    // Word indices (byte offset >> 2)
    localparam logic [WIDX_W-1:0] W_PWR   = 10'h000;
    localparam logic [WIDX_W-1:0] W_CLK   = 10'h001;
    localparam logic [WIDX_W-1:0] W_ARG   = 10'h002;
    localparam logic [WIDX_W-1:0] W_CMD   = 10'h003;
    localparam logic [WIDX_W-1:0] W_RCMD  = 10'h004;
    localparam logic [WIDX_W-1:0] W_RSP0  = 10'h005;
    localparam logic [WIDX_W-1:0] W_RSP1  = 10'h006;
    localparam logic [WIDX_W-1:0] W_RSP2  = 10'h007;
    localparam logic [WIDX_W-1:0] W_RSP3  = 10'h008;
    localparam logic [WIDX_W-1:0] W_DTMR  = 10'h009;
    localparam logic [WIDX_W-1:0] W_DLEN  = 10'h00A;
    localparam logic [WIDX_W-1:0] W_DCTL  = 10'h00B;
    localparam logic [WIDX_W-1:0] W_DCNT  = 10'h00C;
    localparam logic [WIDX_W-1:0] W_STAT  = 10'h00D;
    localparam logic [WIDX_W-1:0] W_CLR   = 10'h00E;
    localparam logic [WIDX_W-1:0] W_MSK0  = 10'h00F;
    localparam logic [WIDX_W-1:0] W_MSK1  = 10'h010;
    localparam logic [WIDX_W-1:0] W_FCNT  = 10'h012;

    // Upper address bits selecting the FIFO window and the ID window
    localparam logic [5:0] FIFO_WIN_HI = 6'h02;
    localparam logic [6:0] ID_WIN_HI   = 7'h7F;

    // Identification byte for word i of the ID window
    function automatic logic [7:0] id_byte(input logic [2:0] i);
        case (i)
            3'd0:    id_byte = 8'h81;
            3'd1:    id_byte = 8'h11;
            3'd2:    id_byte = 8'h04;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/chr_status_irq.sv
// Sticky status bits, live flag merge, mask registers and registered
// interrupt lines. Assumes set pulses and clear writes are single-cycle;
// a set in the same cycle as a clear of the same bit leaves it set.
module chr_status_irq
    import card_host_pkg::*;
#(
    parameter int unsigned E_W = EVT_W,
    parameter int unsigned L_W = LIVE_W,
    parameter int unsigned N   = N_IRQ
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [E_W-1:0]       evt_set,
    input  logic                 clr_we,
    input  logic [E_W-1:0]       clr_bits,
    input  logic [L_W-1:0]       live,
    input  logic [N-1:0]         mask_we,
    input  logic [DW-1:0]        mask_wdata,
    output logic [DW-1:0]        stat_word,
    output logic [N-1:0][DW-1:0] masks,
    output logic [N-1:0]         irq
);
    localparam int unsigned PAD_W = DW - E_W - L_W;

    logic [E_W-1:0] sticky_q;
    logic [DW-1:0]  mask_q [N];
    logic [N-1:0]   irq_q;

    // Sticky event bits: clear on request, set pulses take priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= '0;
        end else begin
            sticky_q <= (sticky_q & ~(clr_we ? clr_bits : '0)) | evt_set;
        end
    end

    assign stat_word = {{PAD_W{1'b0}}, live, sticky_q};

    for (genvar g = 0; g < N; g++) begin : g_line
        // Mask register for interrupt line g
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[g] <= '0;
            end else if (mask_we[g]) begin
                mask_q[g] <= mask_wdata;
            end
        end

        // Registered interrupt line g
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq_q[g] <= 1'b0;
            end else begin
                irq_q[g] <= |(stat_word & mask_q[g]);
            end
        end

        assign masks[g] = mask_q[g];
    end

    assign irq = irq_q;
endmodule

// File: rtl/chr_fifo_port.sv
// Forwards FIFO-window bus accesses to an external show-ahead FIFO.
// Pops combinationally in the read cycle when the FIFO is not empty;
// pushes are registered and dropped while the byte count is zero.
module chr_fifo_port
    import card_host_pkg::*;
#(
    parameter int unsigned CNT_W = LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_rd,
    input  logic             win_wr,
    input  logic [DW-1:0]    wdata,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             fifo_empty,
    input  logic [DW-1:0]    fifo_rdata,
    output logic             fifo_pop,
    output logic             fifo_push,
    output logic [DW-1:0]    fifo_wdata,
    output logic [DW-1:0]    rd_word
);
    logic          push_q;
    logic [DW-1:0] pdata_q;

    // Pop only when a word is present; an empty read yields zero
    always_comb begin
        fifo_pop = win_rd && !fifo_empty;
        rd_word  = fifo_empty ? '0 : fifo_rdata;
    end

    // Register the push strobe and its word, gated by a live transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_q  <= 1'b0;
            pdata_q <= '0;
        end else begin
            push_q <= win_wr && (byte_count != '0);
            if (win_wr && (byte_count != '0)) begin
                pdata_q <= wdata;
            end
        end
    end

    assign fifo_push  = push_q;
    assign fifo_wdata = pdata_q;
endmodule

// File: rtl/chr_read_mux.sv
// Registered read-data multiplexer for the register bank. Assumes the
// caller flags aligned accesses and the two address windows; anything
// else reads zero. Read data holds until the next read.
module chr_read_mux
    import card_host_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic                aligned,
    input  logic [WIDX_W-1:0]   widx,
    input  logic                in_fifo,
    input  logic                in_id,
    input  logic [DW-1:0]       fifo_word,
    input  logic [CFG8_W-1:0]   pwr,
    input  logic [CFG8_W-1:0]   clkc,
    input  logic [DW-1:0]       arg,
    input  logic [CMD_W-1:0]    cmd,
    input  logic [IDX_W-1:0]    rcmd,
    input  logic [RSP_N*DW-1:0] rsp,
    input  logic [DW-1:0]       dtmr,
    input  logic [LEN_W-1:0]    dlen,
    input  logic [CFG8_W-1:0]   dctl,
    input  logic [LEN_W-1:0]    dcnt,
    input  logic [DW-1:0]       stat,
    input  logic [DW-1:0]       msk0,
    input  logic [DW-1:0]       msk1,
    output logic [DW-1:0]       rdata
);
    localparam int unsigned FC_W = LEN_W + 1;

    logic [FC_W-1:0] cnt_plus;
    logic [DW-1:0]   sel;
    logic [DW-1:0]   rdata_q;

    // Select the addressed value
    always_comb begin
        cnt_plus = {1'b0, dcnt} + FC_W'(3);
        sel      = '0;
        if (!aligned) begin
            sel = '0;
        end else if (in_fifo) begin
            sel = fifo_word;
        end else if (in_id) begin
            sel = DW'(id_byte(widx[2:0]));
        end else begin
            case (widx)
                W_PWR:   sel = DW'(pwr);
                W_CLK:   sel = DW'(clkc);
                W_ARG:   sel = arg;
                W_CMD:   sel = DW'(cmd);
                W_RCMD:  sel = DW'(rcmd);
                W_RSP0:  sel = rsp[0*DW +: DW];
                W_RSP1:  sel = rsp[1*DW +: DW];
                W_RSP2:  sel = rsp[2*DW +: DW];
                W_RSP3:  sel = rsp[3*DW +: DW];
                W_DTMR:  sel = dtmr;
                W_DLEN:  sel = DW'(dlen);
                W_DCTL:  sel = DW'(dctl);
                W_DCNT:  sel = DW'(dcnt);
                W_STAT:  sel = stat;
                W_MSK0:  sel = msk0;
                W_MSK1:  sel = msk1;
                W_FCNT:  sel = DW'(cnt_plus[FC_W-1:2]);
                default: sel = '0;
            endcase
        end
    end

    // Capture the selected value on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= sel;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/card_host_regs.sv
// Register and interrupt front end of a card host controller. Decodes a
// simple 32-bit bus, stores configuration, captures responses, hands
// FIFO-window accesses to chr_fifo_port and status/interrupt handling to
// chr_status_irq. Assumes one-cycle bus strobes, never both at once.
module card_host_regs
    import card_host_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    output logic [CFG8_W-1:0]   pwr_ctrl,
    output logic [CFG8_W-1:0]   clk_ctrl,
    output logic [DW-1:0]       cmd_arg,
    output logic [CMD_W-1:0]    cmd_ctrl,
    output logic                cmd_start,
    output logic [DW-1:0]       data_timer,
    output logic [LEN_W-1:0]    data_len,
    output logic [CFG8_W-1:0]   data_ctrl,
    output logic                data_start,
    input  logic                rsp_valid,
    input  logic [IDX_W-1:0]    rsp_index,
    input  logic [RSP_N*DW-1:0] rsp_words,
    input  logic [LEN_W-1:0]    byte_count,
    input  logic [EVT_W-1:0]    evt_set,
    input  logic [LIVE_W-1:0]   live_flags,
    input  logic [DW-1:0]       fifo_rdata,
    input  logic                fifo_empty,
    output logic                fifo_pop,
    output logic                fifo_push,
    output logic [DW-1:0]       fifo_wdata,
    output logic                irq0,
    output logic                irq1
);
    logic [WIDX_W-1:0]   widx;
    logic                aligned;
    logic                in_fifo;
    logic                in_id;
    logic                wr_ok;
    logic                rd_ok;
    logic [CFG8_W-1:0]   pwr_q;
    logic [CFG8_W-1:0]   clk_q;
    logic [DW-1:0]       arg_q;
    logic [CMD_W-1:0]    cmd_q;
    logic                cstart_q;
    logic [DW-1:0]       dtmr_q;
    logic [LEN_W-1:0]    dlen_q;
    logic [CFG8_W-1:0]   dctl_q;
    logic                dstart_q;
    logic [IDX_W-1:0]    rcmd_q;
    logic [RSP_N*DW-1:0] rsp_q;
    logic [DW-1:0]       stat_word;
    logic [N_IRQ-1:0][DW-1:0] masks;
    logic [N_IRQ-1:0]    irq_v;
    logic [N_IRQ-1:0]    mask_we;
    logic [DW-1:0]       fifo_word;

    // Address decode shared by the write and read paths
    always_comb begin
        widx    = bus_addr[AW-1:2];
        aligned = (bus_addr[1:0] == 2'b00);
        in_fifo = (bus_addr[AW-1:6] == FIFO_WIN_HI);
        in_id   = (bus_addr[AW-1:5] == ID_WIN_HI);
        wr_ok   = bus_wr && aligned;
        rd_ok   = bus_rd && aligned;
        mask_we = {wr_ok && widx == W_MSK1, wr_ok && widx == W_MSK0};
    end

    // Configuration registers and start strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q    <= '0;
            clk_q    <= '0;
            arg_q    <= '0;
            cmd_q    <= '0;
            cstart_q <= 1'b0;
            dtmr_q   <= '0;
            dlen_q   <= '0;
            dctl_q   <= '0;
            dstart_q <= 1'b0;
        end else begin
            cstart_q <= 1'b0;
            dstart_q <= 1'b0;
            if (wr_ok) begin
                case (widx)
                    W_PWR:  pwr_q  <= bus_wdata[CFG8_W-1:0];
                    W_CLK:  clk_q  <= bus_wdata[CFG8_W-1:0];
                    W_ARG:  arg_q  <= bus_wdata;
                    W_CMD: begin
                        cmd_q    <= {1'b0, bus_wdata[CMD_W-2:0]};
                        cstart_q <= bus_wdata[CMD_EN_BIT];
                    end
                    W_DTMR: dtmr_q <= bus_wdata;
                    W_DLEN: dlen_q <= bus_wdata[LEN_W-1:0];
                    W_DCTL: begin
                        dctl_q   <= bus_wdata[CFG8_W-1:0];
                        dstart_q <= bus_wdata[0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Response capture from the command engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcmd_q <= '0;
            rsp_q  <= '0;
        end else if (rsp_valid) begin
            rcmd_q <= rsp_index;
            rsp_q  <= rsp_words;
        end
    end

    chr_status_irq #(.E_W(EVT_W), .L_W(LIVE_W), .N(N_IRQ)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_set    (evt_set),
        .clr_we     (wr_ok && widx == W_CLR),
        .clr_bits   (bus_wdata[EVT_W-1:0]),
        .live       (live_flags),
        .mask_we    (mask_we),
        .mask_wdata (bus_wdata),
        .stat_word  (stat_word),
        .masks      (masks),
        .irq        (irq_v)
    );

    chr_fifo_port #(.CNT_W(LEN_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_rd     (rd_ok && in_fifo),
        .win_wr     (wr_ok && in_fifo),
        .wdata      (bus_wdata),
        .byte_count (byte_count),
        .fifo_empty (fifo_empty),
        .fifo_rdata (fifo_rdata),
        .fifo_pop   (fifo_pop),
        .fifo_push  (fifo_push),
        .fifo_wdata (fifo_wdata),
        .rd_word    (fifo_word)
    );

    chr_read_mux u_rmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (bus_rd),
        .aligned   (aligned),
        .widx      (widx),
        .in_fifo   (in_fifo),
        .in_id     (in_id),
        .fifo_word (fifo_word),
        .pwr       (pwr_q),
        .clkc      (clk_q),
        .arg       (arg_q),
        .cmd       (cmd_q),
        .rcmd      (rcmd_q),
        .rsp       (rsp_q),
        .dtmr      (dtmr_q),
        .dlen      (dlen_q),
        .dctl      (dctl_q),
        .dcnt      (byte_count),
        .stat      (stat_word),
        .msk0      (masks[0]),
        .msk1      (masks[1]),
        .rdata     (bus_rdata)
    );

    assign pwr_ctrl   = pwr_q;
    assign clk_ctrl   = clk_q;
    assign cmd_arg    = arg_q;
    assign cmd_ctrl   = cmd_q;
    assign cmd_start  = cstart_q;
    assign data_timer = dtmr_q;
    assign data_len   = dlen_q;
    assign data_ctrl  = dctl_q;
    assign data_start = dstart_q;
    assign irq0       = irq_v[0];
    assign irq1       = irq_v[1];
endmodule

// File: rtl/chr_regs_chk.sv
// Temporal checks on the register front end, attached by bind.
module chr_regs_chk
    import card_host_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [EVT_W-1:0] evt_set,
    input logic [LEN_W-1:0] byte_count,
    input logic [DW-1:0]    stat_word,
    input logic [DW-1:0]    mask0,
    input logic [DW-1:0]    mask1,
    input logic             cmd_start,
    input logic             fifo_push,
    input logic             irq0,
    input logic             irq1
);
    // R7
    irq0_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_word & mask0)) |=> irq0);
    // R7
    irq0_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq0 |-> $past(|(stat_word & mask0)));
    // R7
    irq1_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_word & mask1)) |=> irq1);
    // R3
    cmd_start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> $past(bus_wr && bus_addr == 12'h00C && bus_wdata[CMD_EN_BIT]));
    // R10
    push_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> $past(byte_count != '0));
    // R6
    clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_wr && bus_addr == 12'h038) && $past(evt_set) == '0)
        |-> ((stat_word[EVT_W-1:0] & $past(bus_wdata[EVT_W-1:0])) == '0));
endmodule

bind card_host_regs chr_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .evt_set    (evt_set),
    .byte_count (byte_count),
    .stat_word  (stat_word),
    .mask0      (masks[0]),
    .mask1      (masks[1]),
    .cmd_start  (cmd_start),
    .fifo_push  (fifo_push),
    .irq0       (irq0),
    .irq1       (irq1)
);

// File: tb/card_host_regs_tb.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares
// them one cycle after each read strobe.
module card_host_regs_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [7:0]   pwr_ctrl, clk_ctrl, data_ctrl;
    logic [31:0]  cmd_arg, data_timer, fifo_wdata;
    logic [10:0]  cmd_ctrl;
    logic [15:0]  data_len;
    logic         cmd_start, data_start, fifo_pop, fifo_push, irq0, irq1;
    logic         rsp_valid = 1'b0;
    logic [5:0]   rsp_index = '0;
    logic [127:0] rsp_words = '0;
    logic [15:0]  byte_count = '0;
    logic [10:0]  evt_set = '0;
    logic [10:0]  live_flags = '0;
    logic [31:0]  fifo_rdata = '0;
    logic         fifo_empty = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_pend = 1'b0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    card_host_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwr_ctrl(pwr_ctrl), .clk_ctrl(clk_ctrl), .cmd_arg(cmd_arg),
        .cmd_ctrl(cmd_ctrl), .cmd_start(cmd_start), .data_timer(data_timer),
        .data_len(data_len), .data_ctrl(data_ctrl), .data_start(data_start),
        .rsp_valid(rsp_valid), .rsp_index(rsp_index), .rsp_words(rsp_words),
        .byte_count(byte_count), .evt_set(evt_set), .live_flags(live_flags),
        .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
        .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .irq0(irq0), .irq1(irq1)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: one cycle after a read strobe, compare against the queue
    always @(posedge clk) rd_pend <= bus_rd;
    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_evt(input logic [10:0] v);
        @(negedge clk);
        evt_set = v;
        @(negedge clk);
        evt_set = '0;
    endtask

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        check("R1 irq0", {31'b0, irq0}, 0);
        check("R1 irq1", {31'b0, irq1}, 0);
        check("R1 rdata", bus_rdata, 0);
        rd(12'h000, 0, "R1 power");
        rd(12'h00C, 0, "R1 command");
        rd(12'h034, 0, "R1 status");
        rd(12'h03C, 0, "R1 mask0");
        rd(12'h040, 0, "R1 mask1");
        rd(12'h028, 0, "R1 length");

        // R2: stored widths
        wr(12'h000, 32'hFFFF_FFA5); rd(12'h000, 32'hA5, "R2 power");
        wr(12'h004, 32'h1234_5677); rd(12'h004, 32'h77, "R2 clock");
        wr(12'h028, 32'hABCD_1234); rd(12'h028, 32'h1234, "R2 length");
        wr(12'h008, 32'hDEAD_BEEF); rd(12'h008, 32'hDEAD_BEEF, "R2 argument");
        wr(12'h024, 32'h0F0F_F0F0); rd(12'h024, 32'h0F0F_F0F0, "R2 timer");
        check("R2 arg port", cmd_arg, 32'hDEAD_BEEF);

        // R3: command enable pulse and self-clearing enable bit
        wr(12'h00C, 32'h0000_0452);
        check("R3 start pulse", {31'b0, cmd_start}, 1);
        @(negedge clk);
        check("R3 start single", {31'b0, cmd_start}, 0);
        rd(12'h00C, 32'h052, "R3 readback");
        wr(12'h00C, 32'h0000_0011);
        check("R3 no start", {31'b0, cmd_start}, 0);

        // R4: data start
        wr(12'h02C, 32'h0000_0103);
        check("R4 data start", {31'b0, data_start}, 1);
        rd(12'h02C, 32'h03, "R4 data ctrl");
        wr(12'h02C, 32'h0000_0002);
        check("R4 no start", {31'b0, data_start}, 0);

        // R5: sticky and live status
        live_flags = 11'h5A5;
        pulse_evt(11'h041);
        rd(12'h034, {10'b0, 11'h5A5, 11'h041}, "R5 status");
        pulse_evt(11'h100);
        rd(12'h034, {10'b0, 11'h5A5, 11'h141}, "R5 sticky accumulate");

        // R6: clear only written ones, live flags kept
        wr(12'h038, 32'hFFFF_F001);
        rd(12'h034, {10'b0, 11'h5A5, 11'h140}, "R6 clear");
        // set and clear in the same cycle: set wins
        @(negedge clk);
        bus_addr = 12'h038; bus_wdata = 32'h004; bus_wr = 1'b1; evt_set = 11'h004;
        @(negedge clk);
        bus_wr = 1'b0; evt_set = '0;
        rd(12'h034, {10'b0, 11'h5A5, 11'h144}, "R6 set wins");
        wr(12'h038, 32'h7FF);
        live_flags = '0;
        rd(12'h034, 0, "R6 all clear");

        // R7: masked interrupts, one-cycle latency
        wr(12'h03C, 32'h0000_0008);
        wr(12'h040, 32'h0000_0010);
        rd(12'h03C, 32'h8, "R7 mask0");
        pulse_evt(11'h008);
        check("R7 irq0 not yet", {31'b0, irq0}, 0);
        @(negedge clk);
        check("R7 irq0 high", {31'b0, irq0}, 1);
        check("R7 irq1 low", {31'b0, irq1}, 0);
        wr(12'h038, 32'h008);
        @(negedge clk);
        check("R7 irq0 cleared", {31'b0, irq0}, 0);
        live_flags = 11'h001;          // status bit 11
        wr(12'h040, 32'h0000_0800);
        check("R7 irq1 not yet", {31'b0, irq1}, 0);
        @(negedge clk);
        check("R7 irq1 live", {31'b0, irq1}, 1);
        live_flags = '0;
        @(negedge clk); @(negedge clk);
        check("R7 irq1 drop", {31'b0, irq1}, 0);

        // R8: byte and word counts
        byte_count = 16'd5;
        rd(12'h048, 2, "R8 words 5");
        rd(12'h030, 5, "R8 bytes");
        byte_count = 16'd8;
        rd(12'h048, 2, "R8 words 8");
        byte_count = 16'hFFFF;
        rd(12'h048, 32'h4000, "R8 words max");
        byte_count = 16'd0;
        rd(12'h048, 0, "R8 words 0");

        // R9: FIFO window reads
        fifo_empty = 1'b0; fifo_rdata = 32'hCAFE_F00D;
        @(negedge clk);
        bus_addr = 12'h0A4; bus_rd = 1'b1;
        exp_q.push_back(32'hCAFE_F00D); tag_q.push_back("R9 fifo read");
        #1 check("R9 pop", {31'b0, fifo_pop}, 1);
        @(negedge clk);
        bus_rd = 1'b0;
        fifo_empty = 1'b1;
        @(negedge clk);
        bus_addr = 12'h0BC; bus_rd = 1'b1;
        exp_q.push_back(0); tag_q.push_back("R9 empty read");
        #1 check("R9 no pop", {31'b0, fifo_pop}, 0);
        @(negedge clk);
        bus_rd = 1'b0;

        // R10: FIFO window writes
        byte_count = 0;
        wr(12'h080, 32'h1111_2222);
        check("R10 ignored", {31'b0, fifo_push}, 0);
        byte_count = 16'd12;
        wr(12'h09C, 32'h3333_4444);
        check("R10 push", {31'b0, fifo_push}, 1);
        check("R10 push data", fifo_wdata, 32'h3333_4444);
        @(negedge clk);
        check("R10 single", {31'b0, fifo_push}, 0);
        byte_count = 0;

        // R11: identification bytes
        for (int i = 0; i < 8; i++) begin
            logic [7:0] idv;
            case (i)
                0: idv = 8'h81; 1: idv = 8'h11; 2: idv = 8'h04; 3: idv = 8'h00;
                4: idv = 8'h0D; 5: idv = 8'hF0; 6: idv = 8'h05; default: idv = 8'hB1;
            endcase
            rd(12'hFE0 + 12'(4 * i), {24'b0, idv}, "R11 id byte");
        end

        // R12: unmapped and misaligned
        wr(12'h044, 32'hFFFF_FFFF);
        rd(12'h044, 0, "R12 unmapped");
        wr(12'h001, 32'h0000_0033);
        rd(12'h000, 32'hA5, "R12 misaligned write");
        rd(12'h001, 0, "R12 misaligned read");
        rd(12'h100, 0, "R12 gap");

        // R13: response capture
        @(negedge clk);
        rsp_valid = 1'b1; rsp_index = 6'h2A;
        rsp_words = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
        @(negedge clk);
        rsp_valid = 1'b0; rsp_words = '0;
        rd(12'h010, 32'h2A, "R13 resp index");
        rd(12'h014, 32'h1111_1111, "R13 word0");
        rd(12'h018, 32'h2222_2222, "R13 word1");
        rd(12'h01C, 32'h3333_3333, "R13 word2");
        rd(12'h020, 32'h4444_4444, "R13 word3");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule